// File: doc/BRIEF.md
# Long-Word Bus Master with 16-Bit Word Splitting

This block carries single long-word transfers from an internal requester onto an external system bus, where it is always the bus master. The requester hands over a long-word address, a direction and, for writes, 32 bits of data through a valid/ready handshake. The master then runs one or two bus cycles and returns a single completion pulse. For a read, the completion comes with the 32-bit result.

The static width input selects the bus width. When it is high, one bus cycle moves the whole long word on all 32 data lines with every byte enabled. When it is low, the long word is split into two back-to-back 16-bit cycles on the low data half, and the active-low byte enables mark which half is in flight. The order of the two halves depends on the direction: a read fetches the upper half first, and a write sends the lower half first. The two read halves are joined into one word before completion.

Each bus cycle has four phases: address with strobe, strobe hold, ready sample, and strobe release. The master stays in the sample phase as long as the ready input is not asserted, which inserts one wait clock per extra sample cycle.

Top module: `bus_master_ws`

## Requirements
- R1: During and right after reset, the strobe is high (inactive), the data output enable is low, done is low and the request port reports ready.
- R2: A request is taken on a clock edge where both valid and ready are high. Ready then stays low until the transfer has finished.
- R3: With the width input high, one bus cycle is run. Its byte enables are 0h, bus_data_o carries the full write data, and the full 32-bit read data is returned.
- R4: The strobe (active low) is asserted for at least three clocks per bus cycle and is then released for one clock, so a bus cycle without waits takes four clocks.
- R5: Each clock in the sample phase where bus_rdy_ni is high adds exactly one clock of strobe assertion.
- R6: With the width input low, a read runs two cycles. The first has byte enables 3h and takes the upper half from bus_data_i[15:0]. The second has byte enables Ch and takes the lower half from bus_data_i[15:0]. bus_data_i[31:16] is ignored.
- R7: With the width input low, a write runs two cycles. The first has byte enables Ch and drives write data bits 15:0 on bus_data_o[15:0]. The second has byte enables 3h and drives write data bits 31:16 on bus_data_o[15:0].
- R8: bus_oe_o is high only during the bus cycles of a write and is low for reads and between transfers.
- R9: done_o is a one-clock pulse. Counting from the accepting edge, it rises after 4 plus the waits clocks in 32-bit mode, or 8 plus the waits of both cycles in 16-bit mode. rdata_o holds the read result while done_o is high.
- R10: bus_addr_o equals the accepted long-word address and is constant throughout both cycles of a split transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | Static width select: 1 selects 32-bit cycles, 0 selects two 16-bit cycles |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Master idle, request can be taken |
| req_addr_i | input | 30 | Long-word address (byte address bits 31:2) |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_wdata_i | input | 32 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Assembled read data |
| bus_addr_o | output | 30 | Bus long-word address |
| bus_be_no | output | 4 | Byte enables, active low |
| bus_strobe_no | output | 1 | Bus cycle strobe, active low |
| bus_wr_o | output | 1 | Bus direction, 1 for a write |
| bus_rdy_ni | input | 1 | Ready from memory, active low |
| bus_data_i | input | 32 | Data from the bus |
| bus_data_o | output | 32 | Data to the bus |
| bus_oe_o | output | 1 | Data output enable for the bus tri-state driver |

## Verification
The bench acts as the memory side. At each falling edge it counts how many clocks the strobe has been low. It drives ready low only once the count reaches three plus the wait count chosen for that cycle, so the edge that ends the sample phase sees the ready it should. Byte enables, address, output enable and write data are recorded in the first strobe clock of each cycle. The length of the strobe assertion is recorded when the strobe rises. The bench expects done one clock after the last release, at falling edge number 4·beats + waits + 1 after the accepting edge. It confirms done is low again at the next falling edge and compares the read result against the memory word it supplied, with random junk placed on the unused upper data half.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_HOLD,
    PH_SAMPLE,
    PH_REL
  } phase_e;
endpackage

// File: rtl/bm_fsm.sv
module bm_fsm
  import bm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   two_beats_i,
  input  logic   rdy_ni,
  output phase_e phase_o,
  output logic   beat_o,
  output logic   capture_o,
  output logic   done_o
);
  phase_e phase_q, phase_d;
  logic   beat_q, beat_d;
  logic   done_d;

  always_comb begin
    phase_d = phase_q;
    beat_d  = beat_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_ADDR;
        beat_d  = 1'b0;
      end
      PH_ADDR:   phase_d = PH_HOLD;
      PH_HOLD:   phase_d = PH_SAMPLE;
      PH_SAMPLE: if (!rdy_ni) phase_d = PH_REL;
      PH_REL: begin
        if (two_beats_i && !beat_q) begin
          phase_d = PH_ADDR;
          beat_d  = 1'b1;
        end else begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      beat_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      beat_q  <= beat_d;
      done_o  <= done_d;
    end
  end

  assign phase_o   = phase_q;
  assign beat_o    = beat_q;
  assign capture_o = (phase_q == PH_SAMPLE) && !rdy_ni;

  // wait state: no ready keeps the sample phase
  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SAMPLE && rdy_ni) |=> (phase_q == PH_SAMPLE));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_from_rel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(phase_q) == PH_REL));
endmodule

// File: rtl/bm_lanes.sv
module bm_lanes
  import bm_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W   = DATA_W / 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int HB_W   = BE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              write_i,
  input  logic              beat_i,
  input  phase_e            phase_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [BE_W-1:0]   be_no,
  output logic [DATA_W-1:0] dout_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hi_sel;
  logic active;

  // reads fetch upper half first, writes send lower half first
  assign hi_sel = write_i ? beat_i : !beat_i;
  assign active = (phase_i != PH_IDLE);

  always_comb begin
    if (!active)     be_no = '1;
    else if (wide_i) be_no = '0;
    else if (hi_sel) be_no = {{HB_W{1'b0}}, {HB_W{1'b1}}};
    else             be_no = {{HB_W{1'b1}}, {HB_W{1'b0}}};
  end

  always_comb begin
    if (wide_i)      dout_o = wdata_i;
    else if (hi_sel) dout_o = {{HALF_W{1'b0}}, wdata_i[DATA_W-1:HALF_W]};
    else             dout_o = {{HALF_W{1'b0}}, wdata_i[HALF_W-1:0]};
  end

  assign oe_o = write_i && active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (capture_i && !write_i) begin
      if (wide_i)      rdata_o <= bus_data_i;
      else if (hi_sel) rdata_o[DATA_W-1:HALF_W] <= bus_data_i[HALF_W-1:0];
      else             rdata_o[HALF_W-1:0]      <= bus_data_i[HALF_W-1:0];
    end
  end

  p_be_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> ($countones(be_no) == 0 || $countones(be_no) == HB_W));

  p_be_wide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && wide_i) |-> (be_no == '0));
endmodule

// File: rtl/bus_master_ws.sv
module bus_master_ws
  import bm_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BE_W-1:0]   bus_be_no,
  output logic              bus_strobe_no,
  output logic              bus_wr_o,
  input  logic              bus_rdy_ni,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o
);
  phase_e            phase;
  logic              beat, capture, accept;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      write_q <= req_write_i;
      wdata_q <= req_wdata_i;
    end
  end

  bm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .two_beats_i (!wide_i),
    .rdy_ni      (bus_rdy_ni),
    .phase_o     (phase),
    .beat_o      (beat),
    .capture_o   (capture),
    .done_o      (done_o)
  );

  bm_lanes #(.DATA_W(DATA_W)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wide_i     (wide_i),
    .write_i    (write_q),
    .beat_i     (beat),
    .phase_i    (phase),
    .capture_i  (capture),
    .wdata_i    (wdata_q),
    .bus_data_i (bus_data_i),
    .be_no      (bus_be_no),
    .dout_o     (bus_data_o),
    .oe_o       (bus_oe_o),
    .rdata_o    (rdata_o)
  );

  assign bus_addr_o    = addr_q;
  assign bus_wr_o      = write_q;
  assign bus_strobe_no = !(phase == PH_ADDR || phase == PH_HOLD || phase == PH_SAMPLE);

  p_busy_no_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  p_min_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_strobe_no) |=> !bus_strobe_no ##1 !bus_strobe_no);

  p_addr_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_strobe_no && $past(!bus_strobe_no)) |-> $stable(bus_addr_o));

  p_oe_in_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (!bus_strobe_no || $past(!bus_strobe_no)));

  p_no_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_strobe_no) |-> !req_ready_o);
endmodule

// File: tb/bus_master_ws_bench.sv
module bus_master_ws_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [29:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_strobe_n;
  logic        bus_wr;
  logic        bus_rdy_n = 1'b1;
  logic [31:0] bus_din = '0;
  logic [31:0] bus_dout;
  logic        bus_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_master_ws u_bus_master_ws (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata),
    .bus_addr_o(bus_addr), .bus_be_no(bus_be_n), .bus_strobe_no(bus_strobe_n),
    .bus_wr_o(bus_wr), .bus_rdy_ni(bus_rdy_n), .bus_data_i(bus_din),
    .bus_data_o(bus_dout), .bus_oe_o(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input bit w, input bit wr, input int b);
    if (w) return 4'h0;
    if (wr) return (b == 0) ? 4'hC : 4'h3;
    return (b == 0) ? 4'h3 : 4'hC;
  endfunction

  function automatic logic [15:0] exp_wr_half(input logic [31:0] d, input logic [3:0] be);
    return (be == 4'h3) ? d[31:16] : d[15:0];
  endfunction

  task automatic txn(input bit wr, input logic [29:0] a, input logic [31:0] wd,
                     input logic [31:0] mem, input int w0, input int w1);
    int waits[2];
    logic [3:0]  be_seen[2];
    logic [31:0] dout_seen[2];
    logic        oe_seen[2];
    int low_len[2];
    int beat = -1;
    int cnt = 0;
    int cyc = 0;
    int lat;
    bit got = 0;
    waits[0] = w0; waits[1] = w1;
    low_len[0] = 0; low_len[1] = 0;
    be_seen[0] = '1; be_seen[1] = '1;
    dout_seen[0] = '0; dout_seen[1] = '0;
    oe_seen[0] = 0; oe_seen[1] = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    while (!got && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready while busy", {31'd0, req_ready}, 32'd0);
      end
      if (!bus_strobe_n) begin
        cnt++;
        if (cnt == 1 && beat < 1) begin
          beat++;
          be_seen[beat]   = bus_be_n;
          dout_seen[beat] = bus_dout;
          oe_seen[beat]   = bus_oe;
          chk(bus_addr == a, "R10", "bus address", {2'b0, bus_addr}, {2'b0, a});
        end
        bus_rdy_n = !(cnt >= 3 + waits[beat < 0 ? 0 : beat]);
        if (bus_be_n == 4'h3)      bus_din = {$urandom() % 65536, mem[31:16]};
        else if (bus_be_n == 4'hC) bus_din = {$urandom() % 65536, mem[15:0]};
        else                       bus_din = mem;
      end else begin
        if (cnt != 0 && beat >= 0) low_len[beat] = cnt;
        cnt = 0;
        bus_rdy_n = 1'b1;
        if (done) got = 1;
        else if (beat >= 0)
          chk(bus_oe == wr, "R8", "oe at release", {31'd0, bus_oe}, {31'd0, wr});
      end
    end
    lat = wide ? (4 + w0) : (8 + w0 + w1);
    chk(got, "R9", "done seen", {31'd0, got}, 32'd1);
    chk(cyc == lat + 1, "R9", "done latency", cyc, lat + 1);
    chk(beat + 1 == (wide ? 1 : 2), wide ? "R3" : (wr ? "R7" : "R6"), "bus cycle count",
        beat + 1, wide ? 1 : 2);
    for (int b = 0; b <= beat && b < 2; b++) begin
      chk(be_seen[b] == exp_be(wide, wr, b), wide ? "R3" : (wr ? "R7" : "R6"),
          "byte enables", {28'd0, be_seen[b]}, {28'd0, exp_be(wide, wr, b)});
      chk(low_len[b] == 3 + waits[b], (waits[b] == 0) ? "R4" : "R5", "strobe length",
          low_len[b], 3 + waits[b]);
      chk(oe_seen[b] == wr, "R8", "oe in cycle", {31'd0, oe_seen[b]}, {31'd0, wr});
      if (wr && wide)
        chk(dout_seen[b] == wd, "R3", "wide write data", dout_seen[b], wd);
      else if (wr)
        chk(dout_seen[b][15:0] == exp_wr_half(wd, exp_be(0, 1, b)), "R7", "write half",
            {16'd0, dout_seen[b][15:0]}, {16'd0, exp_wr_half(wd, exp_be(0, 1, b))});
    end
    if (!wr) chk(rdata == mem, wide ? "R3" : "R6", "read data", rdata, mem);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single pulse", {31'd0, done}, 32'd0);
    chk(bus_oe == 1'b0, "R8", "oe idle", {31'd0, bus_oe}, 32'd0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(bus_strobe_n == 1'b1, "R1", "strobe in reset", {31'd0, bus_strobe_n}, 32'd1);
    chk(bus_oe == 1'b0, "R1", "oe in reset", {31'd0, bus_oe}, 32'd0);
    chk(done == 1'b0, "R1", "done in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk(bus_strobe_n == 1'b1, "R1", "strobe after reset", {31'd0, bus_strobe_n}, 32'd1);

    // directed corners, 32-bit mode
    wide = 1'b1;
    txn(0, 30'h3FFF_FFFF, 32'h0, 32'hDEAD_BEEF, 0, 0);
    txn(1, 30'h0000_0001, 32'hCAFE_F00D, 32'h0, 0, 0);
    txn(0, 30'h1234_5678, 32'h0, 32'h8000_0001, 5, 0);
    for (int i = 0; i < 20; i++)
      txn($urandom() % 2, $urandom(), $urandom(), $urandom(), $urandom() % 4, 0);

    repeat (2) @(negedge clk);
    wide = 1'b0;
    @(negedge clk);
    // directed corners, 16-bit mode
    txn(0, 30'h0ABC_DEF0, 32'h0, 32'h1234_ABCD, 0, 0);
    txn(1, 30'h0ABC_DEF1, 32'hA5A5_5A5A, 32'h0, 0, 0);
    txn(0, 30'h2000_0000, 32'h0, 32'hFFFF_0000, 3, 0);
    txn(1, 30'h2000_0004, 32'h0001_FFFE, 32'h0, 0, 4);
    for (int i = 0; i < 30; i++)
      txn($urandom() % 2, $urandom(), $urandom(), $urandom(), $urandom() % 4, $urandom() % 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule